// File: doc/BRIEF.md
# Automatic Frequency Correction Controller

This block corrects a receiver's synthesizer word for the carrier offset that a separate discriminator measures. Each measurement cycle ends with a one-cycle `meas_done` pulse carrying a signed offset estimate. The block clamps the estimate to a selectable range and stores it in a small signed offset register. It then adds the stored offset to the nominal frequency word to produce the corrected word sent to the synthesizer.

The register can be written in two ways. In manual mode a strobe writes it. In the automatic modes it is committed without software help once the valid-data indicator (`vdi`) has stayed high for a whole cycle and two consecutive clamped results agree. The automatic modes differ in what happens after a commit. One commits a single time after reset and then keeps the value. One clears the value whenever `vdi` drops, which suits traffic from many transmitters. One keeps the committed value whatever `vdi` does.

Three status bits are provided:
- `tgl` flips once per measurement cycle.
- `same` reports that two successive results matched.
- `lock` reports that an automatic commit is in force.

Top module: `afc_ctrl`

## Requirements
- R1: The limiter clamps the 8-bit two's-complement `meas` to a symmetric bound chosen by `rng`: code 00 gives ±63, 01 gives ±31, 10 gives ±15 and 11 gives ±7. Values inside the bound pass unchanged.
- R2: While `oe` is 1, `fcorr` equals `fword` plus the 7-bit offset register sign-extended to 12 bits, modulo 4096. While `oe` is 0, `fcorr` equals `fword`. The output is combinational from the register.
- R3: Every `meas_done` pulse while `en` is 1 inverts `tgl`, and the new value is visible the cycle after the pulse.
- R4: After a `meas_done` pulse, `same` is 1 if the clamped result equals the clamped result of the previous pulse since reset or enable, and 0 otherwise.
- R5: In `mode` 00 (manual), a `strobe` pulse loads the clamped `meas` into the offset register at the next edge. `meas_done` never changes the register in this mode, and `lock` stays 0.
- R6: In `mode` 01, 10 and 11, a `meas_done` pulse commits the clamped result and sets `lock` only when two conditions hold. First, `vdi` was 1 in every cycle since the previous pulse (or since reset), including the pulse cycle. Second, the clamped result equals that of the previous pulse.
- R7: In `mode` 01, only the first commit after reset takes effect. Later matching results are ignored, and `vdi` going low does not clear the register.
- R8: In `mode` 10, any cycle with `vdi` at 0 clears the offset register and `lock` at the next edge.
- R9: In `mode` 11, `vdi` at 0 does not clear a committed offset or `lock`.
- R10: `strobe` has no effect in `mode` 01, 10 and 11.
- R11: While `en` is 0, the offset register, `lock`, `tgl` and `same` are held at 0 from the next edge.
- R12: After reset, the offset register, `lock`, `tgl` and `same` are 0, so `fcorr` equals `fword`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low holds the register and status cleared |
| mode | input | 2 | Operating mode: 00 manual, 01 once, 10 track, 11 keep |
| rng | input | 2 | Clamp range code |
| meas | input | 8 | Signed offset measurement, valid with `meas_done` |
| meas_done | input | 1 | End-of-measurement-cycle pulse |
| vdi | input | 1 | Valid-data indicator |
| strobe | input | 1 | Manual load pulse (manual mode only) |
| oe | input | 1 | Apply the offset to the output |
| fword | input | 12 | Nominal frequency control word |
| fcorr | output | 12 | Corrected frequency word |
| tgl | output | 1 | Toggles once per measurement cycle |
| same | output | 1 | Last two results matched |
| lock | output | 1 | Automatic commit in force |

## Verification
The bench builds the block with its default widths: an 8-bit measurement, a 7-bit offset and a 12-bit word. With these widths a single 8-bit stimulus can reach both sides of the widest ±63 clamp, including the -128 extreme. Near 0 and near 4095, the 12-bit word lets the sign-extended sum visibly wrap in both directions. A vector table covers every range code through the manual strobe path. Directed sequences then drive each automatic mode through a `vdi` dropout inside a cycle, matching and non-matching result pairs, and repeated commits.

// File: rtl/afc_pkg.sv
package afc_pkg;

  typedef enum logic [1:0] {
    AFC_MANUAL = 2'b00,
    AFC_ONCE   = 2'b01,
    AFC_TRACK  = 2'b10,
    AFC_KEEP   = 2'b11
  } afc_mode_e;

  // saturate a signed value into [-lim, +lim]
  function automatic int clamp_sym(input int v, input int lim);
    if (v > lim)       return lim;
    else if (v < -lim) return -lim;
    else               return v;
  endfunction

  // clamp bound from the range code: full positive span shifted down
  function automatic int range_bound(input int span_max, input int code);
    return span_max >>> code;
  endfunction

endpackage

// File: rtl/afc_limiter.sv
module afc_limiter
  import afc_pkg::*;
#(
  parameter int MEAS_W = 8,
  parameter int OFS_W  = 7,
  parameter int RNG_W  = 2
) (
  input  logic [MEAS_W-1:0] meas,
  input  logic [RNG_W-1:0]  rng,
  output logic [OFS_W-1:0]  lim_val
);
  localparam int SPAN_MAX = (1 << (OFS_W - 1)) - 1;

  logic signed [MEAS_W-1:0] meas_s;
  int                       bound;
  int                       clamped;

  always_comb begin
    meas_s  = signed'(meas);
    bound   = range_bound(SPAN_MAX, int'(rng));
    clamped = clamp_sym(int'(meas_s), bound);
    lim_val = OFS_W'(clamped);
  end

endmodule

// File: rtl/afc_tracker.sv
module afc_tracker #(
  parameter int OFS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             done,
  input  logic             vdi,
  input  logic [OFS_W-1:0] lim_val,
  output logic             tgl,
  output logic             same,
  output logic             match_now,
  output logic             vdi_full
);
  logic [OFS_W-1:0] last_q;
  logic             have_last_q;
  logic             vdi_win_q;

  assign match_now = have_last_q && (lim_val == last_q);
  assign vdi_full  = vdi_win_q && vdi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl         <= 1'b0;
      same        <= 1'b0;
      last_q      <= '0;
      have_last_q <= 1'b0;
      vdi_win_q   <= 1'b1;
    end else if (!en) begin
      tgl         <= 1'b0;
      same        <= 1'b0;
      last_q      <= '0;
      have_last_q <= 1'b0;
      vdi_win_q   <= 1'b1;
    end else if (done) begin
      tgl         <= ~tgl;
      same        <= match_now;
      last_q      <= lim_val;
      have_last_q <= 1'b1;
      vdi_win_q   <= 1'b1;
    end else if (!vdi) begin
      vdi_win_q   <= 1'b0;
    end
  end

endmodule

// File: rtl/afc_ofs_reg.sv
module afc_ofs_reg
  import afc_pkg::*;
#(
  parameter int OFS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic             strobe,
  input  logic             done,
  input  logic             vdi,
  input  logic             match_now,
  input  logic             vdi_full,
  input  logic [OFS_W-1:0] lim_val,
  output logic [OFS_W-1:0] ofs,
  output logic             lock,
  output logic             once_done,
  output logic             commit_ev,
  output logic             clear_ev,
  output logic             load_ev
);
  afc_mode_e md;
  logic      auto_mode;

  always_comb begin
    md        = afc_mode_e'(mode);
    auto_mode = (md != AFC_MANUAL);
    load_ev   = en && (md == AFC_MANUAL) && strobe;
    commit_ev = en && auto_mode && done && vdi_full && match_now &&
                !((md == AFC_ONCE) && once_done);
    clear_ev  = !en || ((md == AFC_TRACK) && !vdi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs       <= '0;
      lock      <= 1'b0;
      once_done <= 1'b0;
    end else if (clear_ev) begin
      ofs  <= '0;
      lock <= 1'b0;
    end else if (commit_ev) begin
      ofs  <= lim_val;
      lock <= 1'b1;
      if (md == AFC_ONCE) once_done <= 1'b1;
    end else if (load_ev) begin
      ofs  <= lim_val;
      lock <= 1'b0;
    end
  end

endmodule

// File: rtl/afc_adder.sv
module afc_adder #(
  parameter int OFS_W = 7,
  parameter int FW    = 12
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [FW-1:0]    fword,
  input  logic             oe,
  output logic [FW-1:0]    fcorr
);
  localparam int EXT_W = FW - OFS_W;

  logic [FW-1:0] ofs_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
    end else begin : g_trunc
      assign ofs_ext = ofs[FW-1:0];
    end
  endgenerate

  assign fcorr = oe ? (fword + ofs_ext) : fword;

endmodule

// File: rtl/afc_ctrl.sv
module afc_ctrl #(
  parameter int MEAS_W = 8,
  parameter int OFS_W  = 7,
  parameter int FW     = 12,
  parameter int RNG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic [RNG_W-1:0]  rng,
  input  logic [MEAS_W-1:0] meas,
  input  logic              meas_done,
  input  logic              vdi,
  input  logic              strobe,
  input  logic              oe,
  input  logic [FW-1:0]     fword,
  output logic [FW-1:0]     fcorr,
  output logic              tgl,
  output logic              same,
  output logic              lock
);
  logic [OFS_W-1:0] lim_val;
  logic [OFS_W-1:0] ofs_q;
  logic             match_now;
  logic             vdi_full;
  logic             once_done;
  logic             commit_ev;
  logic             clear_ev;
  logic             load_ev;

  afc_limiter #(.MEAS_W(MEAS_W), .OFS_W(OFS_W), .RNG_W(RNG_W)) u_lim (
    .meas    (meas),
    .rng     (rng),
    .lim_val (lim_val)
  );

  afc_tracker #(.OFS_W(OFS_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .done      (meas_done),
    .vdi       (vdi),
    .lim_val   (lim_val),
    .tgl       (tgl),
    .same      (same),
    .match_now (match_now),
    .vdi_full  (vdi_full)
  );

  afc_ofs_reg #(.OFS_W(OFS_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .mode      (mode),
    .strobe    (strobe),
    .done      (meas_done),
    .vdi       (vdi),
    .match_now (match_now),
    .vdi_full  (vdi_full),
    .lim_val   (lim_val),
    .ofs       (ofs_q),
    .lock      (lock),
    .once_done (once_done),
    .commit_ev (commit_ev),
    .clear_ev  (clear_ev),
    .load_ev   (load_ev)
  );

  afc_adder #(.OFS_W(OFS_W), .FW(FW)) u_add (
    .ofs   (ofs_q),
    .fword (fword),
    .oe    (oe),
    .fcorr (fcorr)
  );

endmodule

// File: rtl/afc_ctrl_chk.sv
module afc_ctrl_chk #(
  parameter int OFS_W = 7,
  parameter int FW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       mode,
  input logic             vdi,
  input logic             strobe,
  input logic             meas_done,
  input logic             oe,
  input logic [FW-1:0]    fword,
  input logic [FW-1:0]    fcorr,
  input logic [OFS_W-1:0] ofs,
  input logic             tgl,
  input logic             lock,
  input logic             once_done
);
  localparam int SPAN_MAX = (1 << (OFS_W - 1)) - 1;

  logic signed [OFS_W-1:0] ofs_s;
  assign ofs_s = signed'(ofs);

  AST_OFS_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ofs_s) <= SPAN_MAX) && (int'(ofs_s) >= -SPAN_MAX)); // R1

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> fcorr == fword); // R2

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && meas_done) |=> tgl != $past(tgl)); // R3

  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b00 && !strobe) |=> $stable(ofs)); // R5

  AST_LOCK_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(meas_done)); // R6

  AST_ONCE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b01 && once_done) |=> $stable(ofs)); // R7

  AST_TRACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b10 && !vdi) |=> (ofs == '0) && !lock); // R8

  AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ofs == '0) && !lock && !tgl); // R11

endmodule

bind afc_ctrl afc_ctrl_chk #(.OFS_W(OFS_W), .FW(FW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .mode      (mode),
  .vdi       (vdi),
  .strobe    (strobe),
  .meas_done (meas_done),
  .oe        (oe),
  .fword     (fword),
  .fcorr     (fcorr),
  .ofs       (ofs_q),
  .tgl       (tgl),
  .lock      (lock),
  .once_done (once_done)
);

// File: tb/sim_afc_ctrl.sv
module sim_afc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic        clk = 1'b0;
  logic        rst_n, en, meas_done, vdi, strobe, oe;
  logic [1:0]  mode, rng;
  logic [7:0]  meas;
  logic [11:0] fword, fcorr;
  logic        tgl, same, lock;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  afc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .rng(rng), .meas(meas),
    .meas_done(meas_done), .vdi(vdi), .strobe(strobe), .oe(oe), .fword(fword),
    .fcorr(fcorr), .tgl(tgl), .same(same), .lock(lock)
  );

  // {rng, meas, fword, expected fcorr}
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd0, 8'd10,  12'd100,  12'd110},
    {2'd0, 8'd100, 12'd4090, 12'd57},
    {2'd0, 8'h80,  12'd10,   12'd4043},
    {2'd1, 8'd40,  12'd0,    12'd31},
    {2'd2, 8'hEC,  12'd5,    12'd4086},
    {2'd3, 8'd7,   12'd4095, 12'd6},
    {2'd3, 8'hF8,  12'd2000, 12'd1993},
    {2'd1, 8'hE1,  12'd31,   12'd0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic pulse_done(input logic [7:0] m);
    meas = m; meas_done = 1'b1;
    step();
    meas_done = 1'b0;
  endtask

  task automatic pulse_strobe(input logic [7:0] m);
    meas = m; strobe = 1'b1;
    step();
    strobe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; mode = 2'b00; rng = 2'b00; meas = '0;
    meas_done = 1'b0; vdi = 1'b0; strobe = 1'b0; oe = 1'b0; fword = '0;
    step();
    en = 1'b1; oe = 1'b1; fword = 12'd300;
    do_reset();
    step();
    // R12: reset state
    check(fcorr == 12'd300, "R12 fcorr", fcorr, 300);
    check(!tgl && !same && !lock, "R12 status", {tgl, same, lock}, 0);

    // R1/R2: vector table through the manual strobe path
    for (int i = 0; i < NVEC; i++) begin
      rng   = VEC[i][33:32];
      fword = VEC[i][23:12];
      pulse_strobe(VEC[i][31:24]);
      check(fcorr == VEC[i][11:0], "R1/R2 vector", fcorr, int'(VEC[i][11:0]));
    end
    check(!lock, "R5 lock after strobe", lock, 0);

    // R5: meas_done does not change the register in manual mode (ofs=-31)
    fword = 12'd1000; vdi = 1'b1;
    pulse_done(8'd4);
    pulse_done(8'd4);
    check(fcorr == 12'd969, "R5 manual hold", fcorr, 969);
    check(!lock, "R5 lock", lock, 0);
    // R4: two equal results
    check(same, "R4 same high", same, 1);
    // R3: toggle
    begin
      logic t0;
      t0 = tgl;
      pulse_done(8'd9);
      check(tgl == !t0, "R3 toggle", tgl, !t0);
    end
    check(!same, "R4 same low", same, 0);
    // R2: output disable
    oe = 1'b0; step();
    check(fcorr == 12'd1000, "R2 oe low", fcorr, 1000);
    oe = 1'b1;

    // R6/R8/R10: track mode
    mode = 2'b10; rng = 2'b00; fword = 12'd500; vdi = 1'b1;
    do_reset();
    pulse_strobe(8'd20);
    check(fcorr == 12'd500, "R10 strobe ignored", fcorr, 500);
    pulse_done(8'd12);
    check(fcorr == 12'd500 && !lock, "R6 single result no commit", fcorr, 500);
    pulse_done(8'd12);
    check(fcorr == 12'd512, "R6 commit", fcorr, 512);
    check(lock, "R6 lock set", lock, 1);
    vdi = 1'b0; step();
    check(fcorr == 12'd500, "R8 clear", fcorr, 500);
    check(!lock, "R8 lock cleared", lock, 0);
    vdi = 1'b1;

    // R6/R9: keep mode
    mode = 2'b11;
    do_reset();
    pulse_done(8'd5);
    vdi = 1'b0; step(); vdi = 1'b1;
    pulse_done(8'd5);
    check(fcorr == 12'd500 && !lock, "R6 vdi dropout blocks commit", fcorr, 500);
    pulse_done(8'd5);
    check(fcorr == 12'd505 && lock, "R6 commit after full window", fcorr, 505);
    vdi = 1'b0; step(); step();
    check(fcorr == 12'd505, "R9 kept", fcorr, 505);
    check(lock, "R9 lock kept", lock, 1);
    vdi = 1'b1;

    // R7: once mode
    mode = 2'b01;
    do_reset();
    pulse_done(8'hFD);
    pulse_done(8'hFD);
    check(fcorr == 12'd497, "R7 first commit", fcorr, 497);
    pulse_done(8'd9);
    pulse_done(8'd9);
    check(fcorr == 12'd497, "R7 later commit ignored", fcorr, 497);
    pulse_strobe(8'd30);
    check(fcorr == 12'd497, "R10 strobe ignored once", fcorr, 497);
    vdi = 1'b0; step();
    check(fcorr == 12'd497, "R7 vdi low no clear", fcorr, 497);

    // R11: disable
    en = 1'b0; step();
    check(fcorr == 12'd500, "R11 register cleared", fcorr, 500);
    check(!lock && !tgl && !same, "R11 status cleared", {lock, tgl, same}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule